// File: doc/BRIEF.md
# SPI NAND Command Frame Engine

This block runs one complete command frame on a serial NAND flash bus. The frame is described by a set of descriptor inputs that hold the command byte and three optional phases. The address phase takes a byte count of 0 to 3 and a value. The dummy phase takes a byte count. The data phase takes a direction and a length. The address, dummy and data phases each carry their own lane width of one, two or four lines. The command byte always goes out on a single line. The engine lowers chip select and sends the command, address and dummy bytes. It then moves the data bytes across a byte-wide valid/ready stream, in either direction.

Common flash commands are frames of this shape:
- Reset (0xFF) and write enable (0x06) have no address and no data.
- Erase (0xD8) carries a three-byte row address.
- Feature access (0x0F, 0x1F) carries a one-byte register address and one data byte.
- Cache reads (0x03, 0x3B, 0x6B, 0xBB, 0xEB) carry a two-byte column address and dummy bytes, and widen the later phases.
- The identification read (0x9F) has three forms: bare, with one address byte, or with one dummy byte. Each form is a different descriptor.

The serial clock is idle low and runs in SPI mode 0. When the consumer of read data or the producer of write data is slow, the engine holds the serial clock low between bytes. A new frame is accepted only while the engine is idle. Completion is signalled by a one-cycle pulse on `done`, raised together with chip select.

Top module: `nand_frame_engine`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `io_oe`=0, `io_out`=0, `busy`=0, `done`=0, `rx_valid`=0 and `tx_ready`=0.
- R2: `start` is taken only while `busy` is 0. On acceptance `cs_n` goes low and `busy` goes high at the next clock edge. A `start` pulse or a descriptor change while busy does not alter the running frame.
- R3: Phase order on the wire:
  - The command byte always comes first.
  - The address bytes follow, most significant byte first.
  - The dummy bytes come next, then the data bytes.
  - Any phase with a count of 0 is left out.
  - Every byte is sent most significant bit first.
- R4: Lane code 0 selects x1, 1 selects x2, 2 selects x4, and 3 is treated as x1. The command byte is always x1.
  - In x1, output is on `io_out[0]` and input is sampled from `io_in[1]`.
  - In x2, lines [1:0] are used, with line 1 carrying the higher bit.
  - In x4, lines [3:0] are used, with line 3 carrying the highest bit.
  - `io_oe` enables exactly the lines of an outgoing phase.
- R5: `sck` is low whenever `cs_n` is high. `io_out` does not change at a rising edge of `sck`. `io_in` is sampled at the rising edge of `sck`.
- R6: During dummy bytes `io_oe` is 0. Each dummy byte still takes 8/lanes serial clocks at the dummy lane width.
- R7: Each read byte appears on `rx_data` with `rx_valid`, and is held until `rx_ready`. While a received byte is still unaccepted, no further byte is clocked in.
- R8: In a write data phase, one `tx_data` byte is taken per handshake. While `tx_valid` is low, the engine holds `sck` low before the next data byte. `io_oe` is low throughout a read data phase.
- R9: `done` is a single-cycle pulse. It rises in the same cycle that `cs_n` returns high and `busy` falls.
- R10: A frame produces exactly 8 + Σ(bytes × 8 / lanes) rising `sck` edges, summed over its address, dummy and data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the descriptor |
| opcode | input | 8 | Command byte |
| addr_bytes | input | 2 | Address byte count, 0..3 |
| addr_val | input | 24 | Address value, right-aligned |
| addr_lanes | input | 2 | Address lane code |
| dummy_bytes | input | 3 | Dummy byte count |
| dummy_lanes | input | 2 | Dummy lane code |
| data_write | input | 1 | 1 = data goes to the flash, 0 = data comes back |
| data_len | input | 12 | Data byte count |
| data_lanes | input | 2 | Data lane code |
| busy | output | 1 | Frame in progress |
| done | output | 1 | End-of-frame pulse |
| tx_data | input | 8 | Write data byte |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Engine takes the write byte |
| rx_data | output | 8 | Read data byte |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Consumer takes the read byte |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Serial data lines, outgoing value |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Serial data lines, incoming value |

## Verification
The bench builds the engine with the default three-byte address and three-bit dummy count, and narrows `data_len` to 8 bits. At this size, every address length from 0 to 3, dummy runs up to 7 bytes, and data bursts of several bytes all stay short. Random frames therefore cover every pairing of lane widths across the address, dummy and data phases, including the reserved lane code. Directed frames cover:
- the flash command shapes;
- held-off data streams in both directions;
- a start request raised in the middle of a frame.

The bench replays the captured line activity against the descriptor to rebuild every byte.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam logic [1:0] LANE_X1 = 2'd0;
  localparam logic [1:0] LANE_X2 = 2'd1;
  localparam logic [1:0] LANE_X4 = 2'd2;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_END   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_LOW  = 2'd2,
    S_HIGH = 2'd3
  } seq_state_e;

  // Lines used by a lane code; the reserved code falls back to one line.
  function automatic logic [3:0] lane_mask(input logic [1:0] code);
    case (code)
      LANE_X2: lane_mask = 4'b0011;
      LANE_X4: lane_mask = 4'b1111;
      default: lane_mask = 4'b0001;
    endcase
  endfunction

  // Serial clocks spent on one byte at a lane code.
  function automatic logic [3:0] clocks_per_byte(input logic [1:0] code);
    case (code)
      LANE_X2: clocks_per_byte = 4'd4;
      LANE_X4: clocks_per_byte = 4'd2;
      default: clocks_per_byte = 4'd8;
    endcase
  endfunction

  // First non-empty phase after the current one.
  function automatic phase_e next_phase(input phase_e cur, input logic has_addr,
                                        input logic has_dummy, input logic has_data);
    if (cur == PH_CMD && has_addr)
      next_phase = PH_ADDR;
    else if ((cur == PH_CMD || cur == PH_ADDR) && has_dummy)
      next_phase = PH_DUMMY;
    else if ((cur == PH_CMD || cur == PH_ADDR || cur == PH_DUMMY) && has_data)
      next_phase = PH_DATA;
    else
      next_phase = PH_END;
  endfunction

endpackage

// File: rtl/nand_fe_seq.sv
module nand_fe_seq
  import nand_fe_pkg::*;
#(
  parameter int ADDR_MAX = 3,
  parameter int DUMMY_W  = 3,
  parameter int LEN_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [7:0]                    opcode,
  input  logic [$clog2(ADDR_MAX+1)-1:0] addr_bytes,
  input  logic [8*ADDR_MAX-1:0]         addr_val,
  input  logic [1:0]                    addr_lanes,
  input  logic [DUMMY_W-1:0]            dummy_bytes,
  input  logic [1:0]                    dummy_lanes,
  input  logic                          data_write,
  input  logic [LEN_W-1:0]              data_len,
  input  logic [1:0]                    data_lanes,
  input  logic [7:0]                    tx_data,
  input  logic                          tx_valid,
  input  logic                          rx_pending,
  output logic                          busy,
  output logic                          done,
  output logic                          sck,
  output logic                          cs_n,
  output logic                          tx_ready,
  output logic                          load_en,
  output logic [7:0]                    load_byte,
  output logic                          sample_en,
  output logic                          shift_en,
  output logic                          rx_cap,
  output logic                          drive_en,
  output logic [1:0]                    cur_lanes
);

  localparam int AB_W   = $clog2(ADDR_MAX + 1);
  localparam int ADDR_W = 8 * ADDR_MAX;
  localparam int C1_W   = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W;
  localparam int CNT_W  = (C1_W > AB_W) ? C1_W : AB_W;

  seq_state_e           state_q;
  phase_e               ph_q;
  logic [CNT_W-1:0]     left_q;
  logic [3:0]           clk_left_q;
  logic                 sck_q, cs_q, done_q;

  logic [7:0]           op_q;
  logic [AB_W-1:0]      ab_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [1:0]           al_q, dl_q, ll_q;
  logic [DUMMY_W-1:0]   db_q;
  logic                 wr_q;
  logic [LEN_W-1:0]     len_q;

  logic                 in_data, stall, byte_end, last_byte;
  phase_e               nph;
  logic [CNT_W-1:0]     nph_count;
  logic [ADDR_W-1:0]    addr_shift;
  logic [AB_W-1:0]      ab_clamped;

  assign ab_clamped = (addr_bytes > AB_W'(ADDR_MAX)) ? AB_W'(ADDR_MAX) : addr_bytes;

  always_comb begin
    case (ph_q)
      PH_ADDR:  cur_lanes = al_q;
      PH_DUMMY: cur_lanes = dl_q;
      PH_DATA:  cur_lanes = ll_q;
      default:  cur_lanes = LANE_X1;
    endcase
  end

  assign in_data    = (ph_q == PH_DATA);
  assign stall      = in_data && (wr_q ? !tx_valid : rx_pending);
  assign load_en    = (state_q == S_LOAD) && !stall;
  assign tx_ready   = (state_q == S_LOAD) && in_data && wr_q;
  assign sample_en  = (state_q == S_LOW);
  assign shift_en   = (state_q == S_HIGH);
  assign byte_end   = (state_q == S_HIGH) && (clk_left_q == 4'd1);
  assign last_byte  = (left_q == CNT_W'(1));
  assign rx_cap     = byte_end && in_data && !wr_q;
  assign drive_en   = (state_q != S_IDLE) &&
                      (ph_q == PH_CMD || ph_q == PH_ADDR || (in_data && wr_q));
  assign addr_shift = addr_q >> {left_q - CNT_W'(1), 3'b000};

  always_comb begin
    case (ph_q)
      PH_CMD:  load_byte = op_q;
      PH_ADDR: load_byte = addr_shift[7:0];
      PH_DATA: load_byte = wr_q ? tx_data : 8'h00;
      default: load_byte = 8'h00;
    endcase
  end

  assign nph = next_phase(ph_q, ab_q != '0, db_q != '0, len_q != '0);

  always_comb begin
    case (nph)
      PH_ADDR:  nph_count = CNT_W'(ab_q);
      PH_DUMMY: nph_count = CNT_W'(db_q);
      PH_DATA:  nph_count = CNT_W'(len_q);
      default:  nph_count = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      ph_q       <= PH_CMD;
      left_q     <= '0;
      clk_left_q <= '0;
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      done_q     <= 1'b0;
      op_q       <= '0;
      ab_q       <= '0;
      addr_q     <= '0;
      al_q       <= '0;
      dl_q       <= '0;
      ll_q       <= '0;
      db_q       <= '0;
      wr_q       <= 1'b0;
      len_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            op_q    <= opcode;
            ab_q    <= ab_clamped;
            addr_q  <= addr_val;
            al_q    <= addr_lanes;
            db_q    <= dummy_bytes;
            dl_q    <= dummy_lanes;
            wr_q    <= data_write;
            len_q   <= data_len;
            ll_q    <= data_lanes;
            ph_q    <= PH_CMD;
            left_q  <= CNT_W'(1);
            cs_q    <= 1'b0;
            state_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (load_en) begin
            clk_left_q <= clocks_per_byte(cur_lanes);
            state_q    <= S_LOW;
          end
        end
        S_LOW: begin
          sck_q   <= 1'b1;
          state_q <= S_HIGH;
        end
        default: begin
          sck_q <= 1'b0;
          if (clk_left_q == 4'd1) begin
            if (!last_byte) begin
              left_q  <= left_q - CNT_W'(1);
              state_q <= S_LOAD;
            end else if (nph == PH_END) begin
              cs_q    <= 1'b1;
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              ph_q    <= nph;
              left_q  <= nph_count;
              state_q <= S_LOAD;
            end
          end else begin
            clk_left_q <= clk_left_q - 4'd1;
            state_q    <= S_LOW;
          end
        end
      endcase
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign sck  = sck_q;
  assign cs_n = cs_q;

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> !cs_q); // R5
  AST_DONE_WITH_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $rose(cs_q)); // R9
  AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> $past(state_q == S_IDLE)); // R2
  AST_CLK_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOW || state_q == S_HIGH) |-> (clk_left_q != 4'd0 && clk_left_q <= 4'd8)); // R10
  AST_TX_READY_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!sck_q && !cs_q)); // R8

endmodule

// File: rtl/nand_fe_shifter.sv
module nand_fe_shifter
  import nand_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  input  logic       shift_en,
  input  logic       sample_en,
  input  logic       drive_en,
  input  logic [1:0] lanes,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic [7:0] rx_byte
);

  logic [7:0] tx_q, rx_q;
  logic [3:0] raw_out;

  // Outgoing bits move on the falling serial edge, incoming on the rising one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_en)
        tx_q <= load_byte;
      else if (shift_en) begin
        case (lanes)
          LANE_X2: tx_q <= {tx_q[5:0], 2'b00};
          LANE_X4: tx_q <= {tx_q[3:0], 4'b0000};
          default: tx_q <= {tx_q[6:0], 1'b0};
        endcase
      end
      if (sample_en) begin
        case (lanes)
          LANE_X2: rx_q <= {rx_q[5:0], io_in[1:0]};
          LANE_X4: rx_q <= {rx_q[3:0], io_in[3:0]};
          default: rx_q <= {rx_q[6:0], io_in[1]};
        endcase
      end
    end
  end

  always_comb begin
    case (lanes)
      LANE_X2: raw_out = {2'b00, tx_q[7:6]};
      LANE_X4: raw_out = tx_q[7:4];
      default: raw_out = {3'b000, tx_q[7]};
    endcase
  end

  assign io_oe   = drive_en ? lane_mask(lanes) : 4'b0000;
  assign io_out  = raw_out & io_oe;
  assign rx_byte = rx_q;

endmodule

// File: rtl/nand_fe_rxhold.sv
module nand_fe_rxhold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic [7:0] cap_byte,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (cap) begin
      rx_data  <= cap_byte;
      rx_valid <= 1'b1;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7

endmodule

// File: rtl/nand_frame_engine.sv
module nand_frame_engine #(
  parameter int ADDR_MAX = 3,
  parameter int DUMMY_W  = 3,
  parameter int LEN_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [7:0]                    opcode,
  input  logic [$clog2(ADDR_MAX+1)-1:0] addr_bytes,
  input  logic [8*ADDR_MAX-1:0]         addr_val,
  input  logic [1:0]                    addr_lanes,
  input  logic [DUMMY_W-1:0]            dummy_bytes,
  input  logic [1:0]                    dummy_lanes,
  input  logic                          data_write,
  input  logic [LEN_W-1:0]              data_len,
  input  logic [1:0]                    data_lanes,
  output logic                          busy,
  output logic                          done,
  input  logic [7:0]                    tx_data,
  input  logic                          tx_valid,
  output logic                          tx_ready,
  output logic [7:0]                    rx_data,
  output logic                          rx_valid,
  input  logic                          rx_ready,
  output logic                          sck,
  output logic                          cs_n,
  output logic [3:0]                    io_out,
  output logic [3:0]                    io_oe,
  input  logic [3:0]                    io_in
);

  logic       load_en, sample_en, shift_en, rx_cap, drive_en;
  logic [7:0] load_byte, rx_byte;
  logic [1:0] cur_lanes;

  nand_fe_seq #(
    .ADDR_MAX (ADDR_MAX),
    .DUMMY_W  (DUMMY_W),
    .LEN_W    (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .opcode      (opcode),
    .addr_bytes  (addr_bytes),
    .addr_val    (addr_val),
    .addr_lanes  (addr_lanes),
    .dummy_bytes (dummy_bytes),
    .dummy_lanes (dummy_lanes),
    .data_write  (data_write),
    .data_len    (data_len),
    .data_lanes  (data_lanes),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .rx_pending  (rx_valid),
    .busy        (busy),
    .done        (done),
    .sck         (sck),
    .cs_n        (cs_n),
    .tx_ready    (tx_ready),
    .load_en     (load_en),
    .load_byte   (load_byte),
    .sample_en   (sample_en),
    .shift_en    (shift_en),
    .rx_cap      (rx_cap),
    .drive_en    (drive_en),
    .cur_lanes   (cur_lanes)
  );

  nand_fe_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_byte (load_byte),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .drive_en  (drive_en),
    .lanes     (cur_lanes),
    .io_in     (io_in),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .rx_byte   (rx_byte)
  );

  nand_fe_rxhold u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (rx_cap),
    .cap_byte (rx_byte),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  AST_OUT_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> ($stable(io_out) && $stable(io_oe))); // R5
  AST_IDLE_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000 && !sck)); // R1

endmodule

// File: tb/test_nand_frame_engine.sv
module test_nand_frame_engine;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [1:0]  addr_bytes = '0;
  logic [23:0] addr_val = '0;
  logic [1:0]  addr_lanes = '0;
  logic [2:0]  dummy_bytes = '0;
  logic [1:0]  dummy_lanes = '0;
  logic        data_write = 1'b0;
  logic [LEN_W-1:0] data_len = '0;
  logic [1:0]  data_lanes = '0;
  logic        busy, done, tx_ready, rx_valid, sck, cs_n;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b0;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0] tx_s [0:63];
  logic [7:0] rx_s [0:63];
  logic [7:0] rx_got [0:63];
  logic [3:0] cap_o [0:1023];
  logic [3:0] cap_e [0:1023];

  nand_frame_engine #(.ADDR_MAX(3), .DUMMY_W(3), .LEN_W(LEN_W)) i_nand_frame_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .addr_bytes(addr_bytes), .addr_val(addr_val), .addr_lanes(addr_lanes),
    .dummy_bytes(dummy_bytes), .dummy_lanes(dummy_lanes),
    .data_write(data_write), .data_len(data_len), .data_lanes(data_lanes),
    .busy(busy), .done(done), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .sck(sck), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int nlanes(input logic [1:0] code);
    return (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 1;
  endfunction

  function automatic int cpb(input logic [1:0] code);
    return 8 / nlanes(code);
  endfunction

  function automatic logic [3:0] lmask(input logic [1:0] code);
    return 4'((1 << nlanes(code)) - 1);
  endfunction

  // Rebuild one byte from captured clocks starting at index k.
  function automatic logic [7:0] rebuild(input int k, input logic [1:0] code);
    logic [7:0] v = '0;
    int l = nlanes(code);
    for (int c = 0; c < 8 / l; c++)
      v = 8'((v << l) | (cap_o[k + c] & lmask(code)));
    return v;
  endfunction

  task automatic run_frame(input logic [7:0] op, input int ab, input logic [23:0] av,
                           input logic [1:0] al, input int db, input logic [1:0] dl,
                           input bit wr, input int len, input logic [1:0] ll,
                           input int stall_n, input int rdy_pct, input bit poke);
    int rises = 0, rx_n = 0, tx_idx = 0, cyc = 0, r5_bad = 0, oe_bad = 0;
    int ds, total, k;
    bit pend_tx = 0, prev_sck = 0, got_done = 0;
    logic [3:0] prev_out = '0;
    logic [31:0] rnd;
    bit ok_bytes;
    for (int i = 0; i < 64; i++) begin
      tx_s[i] = 8'($urandom);
      rx_s[i] = 8'($urandom);
      rx_got[i] = '0;
    end
    ds    = 8 + ab * cpb(al) + db * cpb(dl);
    total = ds + len * cpb(ll);
    @(negedge clk);
    opcode = op; addr_bytes = 2'(ab); addr_val = av; addr_lanes = al;
    dummy_bytes = 3'(db); dummy_lanes = dl; data_write = wr;
    data_len = LEN_W'(len); data_lanes = ll; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cs_n == 1'b0 && busy == 1'b1, "R2", "accept lowers cs_n/raises busy",
          {cs_n, busy}, 2'b01);
    while (!got_done && cyc < 6000) begin
      if (sck && !prev_sck) begin
        if (io_out != prev_out) r5_bad++;
        if (rises < 1024) begin
          cap_o[rises] = io_out;
          cap_e[rises] = io_oe;
        end
        rises++;
      end
      prev_sck = sck;
      prev_out = io_out;
      if (poke && cyc == 5) begin start = 1'b1; opcode = ~op; addr_val = ~av; end
      if (poke && cyc == 6) begin start = 1'b0; opcode = op; addr_val = av; end
      if (!sck) begin
        rnd = $urandom;
        if (!wr && rises >= ds && rises < total) begin
          int j = rises - ds, c = cpb(ll), l = nlanes(ll);
          logic [7:0] bits = 8'((rx_s[j / c] >> (8 - l * (j % c + 1))) & ((1 << l) - 1));
          if (l == 1) io_in = {rnd[3:2], bits[0], rnd[0]};
          else if (l == 2) io_in = {rnd[3:2], bits[1:0]};
          else io_in = bits[3:0];
        end else io_in = rnd[3:0];
      end
      if (stall_n > 0 && cyc == stall_n - 1) begin
        int fz = wr ? ds : ds + cpb(ll);
        check(rises == fz && !sck, wr ? "R8" : "R7", "clock held during stall", rises, fz);
        if (!wr) check(rx_valid == 1'b1 && rx_data == rx_s[0], "R7",
                       "held rx byte", rx_data, rx_s[0]);
      end
      rx_ready = (cyc < stall_n) ? 1'b0 : (($urandom % 100) < rdy_pct);
      if (rx_valid && rx_ready && rx_n < 64) begin rx_got[rx_n] = rx_data; rx_n++; end
      if (pend_tx) tx_idx++;
      tx_valid = (cyc >= stall_n) && (($urandom % 100) < rdy_pct) && (tx_idx < len);
      tx_data = tx_s[tx_idx % 64];
      pend_tx = tx_valid && tx_ready;
      if (done) got_done = 1;
      else begin @(negedge clk); cyc++; end
    end
    if (!got_done) check(0, "R9", "frame never completed", cyc, 0);
    check(cs_n == 1'b1 && busy == 1'b0, "R9", "cs_n high and busy low with done",
          {cs_n, busy}, 2'b10);
    tx_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i == 0) check(done == 1'b0, "R9", "done is single-cycle", done, 0);
      rx_ready = 1'b1;
      if (rx_valid && rx_n < 64) begin rx_got[rx_n] = rx_data; rx_n++; end
    end
    rx_ready = 1'b0;
    check(rises == total, "R10", "rising sck count", rises, total);
    check(r5_bad == 0, "R5", "io_out changed at rising sck", r5_bad, 0);
    // Walk the captured clocks phase by phase.
    k = 0;
    check(rebuild(0, 2'd0) == op && cap_e[0] == 4'b0001, "R3", "command byte x1",
          rebuild(0, 2'd0), op);
    for (int c = 0; c < 8; c++) if (cap_e[c] != 4'b0001) oe_bad++;
    k = 8;
    ok_bytes = 1;
    for (int i = 0; i < ab; i++) begin
      logic [7:0] e = 8'(av >> (8 * (ab - 1 - i)));
      if (rebuild(k, al) != e) ok_bytes = 0;
      for (int c = 0; c < cpb(al); c++) if (cap_e[k + c] != lmask(al)) oe_bad++;
      k += cpb(al);
    end
    check(ok_bytes, "R3", "address bytes high first", ab, al);
    for (int i = 0; i < db * cpb(dl); i++) if (cap_e[k + i] != 4'b0000) oe_bad++;
    k += db * cpb(dl);
    check(oe_bad == 0, "R6", "enables in command/address/dummy phases", oe_bad, 0);
    oe_bad = 0;
    ok_bytes = 1;
    for (int i = 0; i < len && k + cpb(ll) <= 1024; i++) begin
      if (wr && rebuild(k, ll) != tx_s[i]) ok_bytes = 0;
      for (int c = 0; c < cpb(ll); c++)
        if (cap_e[k + c] != (wr ? lmask(ll) : 4'b0000)) oe_bad++;
      k += cpb(ll);
    end
    if (len > 0) begin
      if (wr) check(ok_bytes && oe_bad == 0 && tx_idx == len, "R8",
                    "write bytes on data lanes", tx_idx, len);
      else begin
        for (int i = 0; i < len; i++) if (rx_got[i] != rx_s[i]) ok_bytes = 0;
        check(ok_bytes && rx_n == len, "R7", "read bytes delivered in order", rx_n, len);
        check(oe_bad == 0, "R4", "lines released for read data", oe_bad, 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired (R9)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3 + 1);
    check(cs_n && !sck && io_oe == 0 && io_out == 0 && !busy && !done && !rx_valid && !tx_ready,
          "R1", "state during reset",
          {cs_n, sck, io_oe, busy, done, rx_valid, tx_ready}, 10'h200);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !sck && io_oe == 0 && !busy && !done, "R1", "state after reset",
          {cs_n, sck, io_oe, busy, done}, 8'h80);

    // Directed command shapes (R3, R4).
    run_frame(8'hFF, 0, 24'h0, 0, 0, 0, 0, 0, 0, 0, 100, 0);
    run_frame(8'h06, 0, 24'h0, 0, 0, 0, 0, 0, 0, 0, 100, 0);
    run_frame(8'h9F, 0, 24'h0, 0, 0, 0, 0, 2, 0, 0, 100, 0);
    run_frame(8'h9F, 1, 24'h00, 0, 0, 0, 0, 2, 0, 0, 100, 0);
    run_frame(8'h9F, 0, 24'h0, 0, 1, 0, 0, 2, 0, 0, 100, 0);
    run_frame(8'h0F, 1, 24'hC0, 0, 0, 0, 0, 1, 0, 0, 100, 0);
    run_frame(8'h1F, 1, 24'hA0, 0, 0, 0, 1, 1, 0, 0, 100, 0);
    run_frame(8'hD8, 3, 24'h12A5C3, 0, 0, 0, 0, 0, 0, 0, 100, 0);
    run_frame(8'h3B, 2, 24'h0456, 0, 1, 0, 0, 4, 1, 0, 100, 0);
    run_frame(8'h6B, 2, 24'h0789, 0, 1, 0, 0, 5, 2, 0, 100, 0);
    run_frame(8'hBB, 2, 24'h0ABC, 1, 1, 1, 0, 4, 1, 0, 100, 0);
    run_frame(8'hEB, 2, 24'h0DEF, 2, 2, 2, 0, 4, 2, 0, 100, 0);
    run_frame(8'h32, 2, 24'h0100, 0, 0, 0, 1, 6, 2, 0, 100, 0);
    run_frame(8'h02, 2, 24'h0002, 0, 0, 0, 1, 3, 0, 0, 100, 0);
    // Reserved lane code behaves as x1 (R4).
    run_frame(8'h0B, 2, 24'h0F0F, 3, 1, 3, 0, 3, 3, 0, 100, 0);
    // Held-off streams (R7, R8).
    run_frame(8'h03, 2, 24'h0033, 0, 1, 0, 0, 3, 0, 200, 60, 0);
    run_frame(8'h84, 2, 24'h0044, 0, 0, 0, 1, 3, 2, 200, 60, 0);
    // Start raised mid-frame is ignored (R2).
    run_frame(8'h13, 3, 24'h00ABCD, 0, 0, 0, 0, 0, 0, 0, 100, 1);

    // Constrained random frames.
    for (int n = 0; n < 40; n++) begin
      run_frame(8'($urandom), int'($urandom % 4), 24'($urandom), 2'($urandom),
                int'($urandom % 4), 2'($urandom), 1'($urandom), int'($urandom % 9),
                2'($urandom), 0, 40 + int'($urandom % 61), ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule